// File: doc/BRIEF.md
# SPI Host Serial Shift Engine

This block is the serial core of an SPI host. It divides a fast functional clock down to the serial clock, shifts one 8-bit or 16-bit word at a time onto the data output, and collects the word returned on the data input. Words enter through a valid/ready transmit port and leave through a valid/ready receive port. The surrounding chip supplies static configuration inputs: divider, clock idle level, sampling phase, bit order, word length, duplex or receive-only operation, and the target-select pin behaviour.

Shifting starts while `run` is high. The engine also needs a free receive slot and, in full-duplex operation, a transmit word. In receive-only operation it keeps clocking words while `run` stays high and each returned word is taken, and it drives ones on the data output. If `run` is dropped mid-word, the word still completes. `busy` then falls as the serial clock returns to its idle level.

Top module: `spi_host_shifter`

## Requirements
- R1: With divider value N (`cfg_div`, 14 bits, 0 treated as 1), every serial-clock half period lasts N functional clocks, so one word keeps `busy` high for exactly 2·W·N clock cycles (W = word length).
- R2: The serial clock rests at the inverse of `cfg_ckp` whenever `busy` is low (`cfg_ckp`=1 means idle low, `cfg_ckp`=0 means idle high).
- R3: `cfg_dap`=1 samples `miso` on the leading (first) edge of each bit and changes `mosi` on the trailing edge. `cfg_dap`=0 changes `mosi` on the leading edge and samples on the trailing edge.
- R4: `cfg_lsb_first`=1 sends and receives bit 0 first. `cfg_lsb_first`=0 sends and receives the most significant bit of the word first.
- R5: `cfg_wide`=1 shifts 16-bit words (data bits 15:0, 32 clock edges). `cfg_wide`=0 shifts 8-bit words (bits 7:0, 16 edges), and the received word has zeros in bits 15:8.
- R6: `cfg_duplex`=1 sends the accepted `tx_data` word while receiving. `cfg_duplex`=0 is receive-only: `tx_ready` stays low and `mosi` is held at 1 for the whole word.
- R7: A word starts only when `run` is high, `busy` is low, `rx_valid` is low and, in duplex operation, a transmit word is accepted (`tx_valid` and `tx_ready` high together). `rx_valid` rises as `busy` falls and holds, with `rx_data` unchanged, until `rx_ready`. No further word starts before that.
- R8: If `run` is cleared while a word is in flight, the word completes in full and `busy` stays high until its last clock edge.
- R9: The target-select output `sel` is held at 0 when `cfg_sel_en`=0. When `cfg_sel_en`=1, it equals `cfg_sel_pol` while `busy` is high and the inverse of `cfg_sel_pol` otherwise, so `cfg_sel_pol`=1 is active-high and 0 is active-low.
- R10: After reset, `busy`, `rx_valid` and `tx_ready` are low, the serial clock is at its idle level and `sel` is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | 14 | Half-period length in clock cycles (0 acts as 1) |
| cfg_ckp | input | 1 | Inverse of the serial clock idle level |
| cfg_dap | input | 1 | Phase select, inverse of the usual phase bit |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_wide | input | 1 | 1: 16-bit words, 0: 8-bit words |
| cfg_duplex | input | 1 | 1: transmit and receive, 0: receive only |
| cfg_sel_en | input | 1 | Enables driving of the target-select output |
| cfg_sel_pol | input | 1 | Active level of the target-select output |
| run | input | 1 | Enable; words start while high |
| busy | output | 1 | High while a word is shifting |
| tx_data | input | 16 | Word to transmit |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Transmit word accepted this cycle when valid |
| rx_data | output | 16 | Received word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Sink takes the received word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel | output | 1 | Target-select output |

## Verification
A word begins on the clock edge that accepts the start condition. The first serial-clock edge follows N cycles later, and each further edge follows N cycles after the previous one. `busy` falls and `rx_valid` rises on the same edge that produces the final serial-clock edge, 2·W·N cycles after the start. The bench samples every output on the falling functional clock, so all of these registered changes are already settled when it looks. Its target model reacts to each serial-clock edge in the half period that follows: it presents the next `miso` bit after each sampling edge and reads `mosi` just after the sampling edges. `rx_valid` must clear one cycle after `rx_ready`, and when receive-only operation is resumed the next word must appear within a few cycles.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  localparam int WORD_W = 16;
  localparam int DIV_W  = 14;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } seq_state_t;

endpackage

// File: rtl/spi_host_baud.sv
module spi_host_baud #(
  parameter int DIV_W = spi_host_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  // A zero divider behaves as one
  always_comb lim = (div == '0) ? ONE : div;

  assign tick = en && (cnt == (lim - ONE));

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + ONE;
  end

endmodule

// File: rtl/spi_host_shreg.sv
module spi_host_shreg #(
  parameter int WORD_W = spi_host_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              lsb_first,
  input  logic              wide,
  input  logic              duplex,
  input  logic              shift_tx,
  input  logic              sample,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word
);

  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] txsh;
  logic [WORD_W-1:0] rxsh;
  logic [WORD_W-1:0] rx_next;
  logic [WORD_W-1:0] load_val;
  logic [WORD_W-1:0] tx_flip;

  // Transmit word reversed end to end: bit 0 lands at the top
  always_comb begin
    for (int i = 0; i < WORD_W; i++) tx_flip[i] = tx_word[WORD_W-1-i];
  end

  // Top bit of the transmit register is always the next bit on the wire
  always_comb begin
    if (!duplex)        load_val = '1;
    else if (lsb_first) load_val = tx_flip;
    else if (wide)      load_val = tx_word;
    else                load_val = {tx_word[HALF_W-1:0], {HALF_W{1'b0}}};
  end

  always_comb rx_next = sample ? {rxsh[WORD_W-2:0], miso} : rxsh;

  // First bit received sits highest in the filled part of rx_next
  always_comb begin
    rx_word = '0;
    if (wide) begin
      for (int i = 0; i < WORD_W; i++)
        rx_word[i] = lsb_first ? rx_next[WORD_W-1-i] : rx_next[i];
    end else begin
      for (int i = 0; i < HALF_W; i++)
        rx_word[i] = lsb_first ? rx_next[HALF_W-1-i] : rx_next[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txsh <= '1;
      rxsh <= '0;
    end else if (load) begin
      txsh <= load_val;
      rxsh <= '0;
    end else begin
      if (shift_tx) txsh <= {txsh[WORD_W-2:0], 1'b1};
      rxsh <= rx_next;
    end
  end

  assign mosi = txsh[WORD_W-1];

endmodule

// File: rtl/spi_host_seq.sv
module spi_host_seq #(
  parameter int WORD_W = spi_host_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              duplex,
  input  logic              wide,
  input  logic              cpha,
  input  logic              tx_valid,
  input  logic              rx_ready,
  input  logic              tick,
  input  logic [WORD_W-1:0] rx_word,
  output logic              busy,
  output logic              phase,
  output logic              load,
  output logic              shift_tx,
  output logic              sample,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data
);

  import spi_host_pkg::*;

  localparam int EDGE_W = $clog2(2 * WORD_W);
  localparam logic [EDGE_W-1:0] LAST_WIDE   = EDGE_W'(2 * WORD_W - 1);
  localparam logic [EDGE_W-1:0] LAST_NARROW = EDGE_W'(WORD_W - 1);

  seq_state_t        state;
  logic [EDGE_W-1:0] ecnt;
  logic [EDGE_W-1:0] last_e;
  logic              idle_ok;
  logic              start;

  assign last_e  = wide ? LAST_WIDE : LAST_NARROW;
  assign busy    = (state == ST_SHIFT);
  assign idle_ok = (state == ST_IDLE) && run && !rx_valid;
  assign tx_ready = idle_ok && duplex;
  assign start   = idle_ok && (!duplex || tx_valid);
  assign load    = start;

  // Even edge count = leading edge of a bit
  assign sample   = tick && (cpha ? ecnt[0] : !ecnt[0]);
  assign shift_tx = tick && (cpha ? (!ecnt[0] && (ecnt != '0)) : ecnt[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ecnt     <= '0;
      phase    <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_SHIFT;
            ecnt  <= '0;
            phase <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            phase <= ~phase;
            if (ecnt == last_e) begin
              state    <= ST_IDLE;
              rx_valid <= 1'b1;
              rx_data  <= rx_word;
            end else begin
              ecnt <= ecnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter #(
  parameter int WORD_W = spi_host_pkg::WORD_W,
  parameter int DIV_W  = spi_host_pkg::DIV_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_ckp,
  input  logic              cfg_dap,
  input  logic              cfg_lsb_first,
  input  logic              cfg_wide,
  input  logic              cfg_duplex,
  input  logic              cfg_sel_en,
  input  logic              cfg_sel_pol,
  input  logic              run,
  output logic              busy,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              sel
);

  logic              tick;
  logic              phase;
  logic              load;
  logic              shift_tx;
  logic              sample;
  logic              cpol;
  logic              cpha;
  logic [WORD_W-1:0] rx_word;

  // Configuration bits carry the inverse of the usual mode bits
  assign cpol = ~cfg_ckp;
  assign cpha = ~cfg_dap;

  spi_host_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst  (rst),
    .en   (busy),
    .div  (cfg_div),
    .tick (tick)
  );

  spi_host_seq #(.WORD_W(WORD_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .duplex   (cfg_duplex),
    .wide     (cfg_wide),
    .cpha     (cpha),
    .tx_valid (tx_valid),
    .rx_ready (rx_ready),
    .tick     (tick),
    .rx_word  (rx_word),
    .busy     (busy),
    .phase    (phase),
    .load     (load),
    .shift_tx (shift_tx),
    .sample   (sample),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .rx_data  (rx_data)
  );

  spi_host_shreg #(.WORD_W(WORD_W)) u_shreg (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .tx_word   (tx_data),
    .lsb_first (cfg_lsb_first),
    .wide      (cfg_wide),
    .duplex    (cfg_duplex),
    .shift_tx  (shift_tx),
    .sample    (sample),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_word)
  );

  assign sclk = phase ^ cpol;
  assign sel  = cfg_sel_en & (busy ? cfg_sel_pol : ~cfg_sel_pol);

endmodule

// File: rtl/spi_host_shifter_chk.sv
module spi_host_shifter_chk #(
  parameter int WORD_W = spi_host_pkg::WORD_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_ckp,
  input logic              cfg_duplex,
  input logic              cfg_sel_en,
  input logic              cfg_sel_pol,
  input logic              busy,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [WORD_W-1:0] rx_data,
  input logic              sclk,
  input logic              mosi,
  input logic              sel
);

  AST_IDLE_CLOCK_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sclk == !cfg_ckp)); // R2

  AST_RX_ONLY_ONES: assert property (@(posedge clk) disable iff (rst)
    (busy && !cfg_duplex) |-> mosi); // R6

  AST_TX_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (!busy && !rx_valid)); // R7

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R7

  AST_DONE_DELIVERS: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> rx_valid); // R7

  AST_SEL_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (cfg_sel_en && busy) |-> (sel == cfg_sel_pol)); // R9

  AST_SEL_INACTIVE: assert property (@(posedge clk) disable iff (rst)
    (cfg_sel_en && !busy) |-> (sel != cfg_sel_pol)); // R9

endmodule

bind spi_host_shifter spi_host_shifter_chk #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_ckp     (cfg_ckp),
  .cfg_duplex  (cfg_duplex),
  .cfg_sel_en  (cfg_sel_en),
  .cfg_sel_pol (cfg_sel_pol),
  .busy        (busy),
  .tx_ready    (tx_ready),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .rx_data     (rx_data),
  .sclk        (sclk),
  .mosi        (mosi),
  .sel         (sel)
);

// File: tb/spi_host_shifter_test.sv
`timescale 1ns/1ps
module spi_host_shifter_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] cfg_div = 14'd2;
  logic        cfg_ckp = 1'b1;
  logic        cfg_dap = 1'b1;
  logic        cfg_lsb_first = 1'b0;
  logic        cfg_wide = 1'b0;
  logic        cfg_duplex = 1'b1;
  logic        cfg_sel_en = 1'b1;
  logic        cfg_sel_pol = 1'b0;
  logic        run = 1'b0;
  logic        busy;
  logic [15:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [15:0] rx_data;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic        sclk;
  logic        mosi;
  logic        miso = 1'b0;
  logic        sel;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spi_host_shifter uut (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_ckp(cfg_ckp), .cfg_dap(cfg_dap),
    .cfg_lsb_first(cfg_lsb_first), .cfg_wide(cfg_wide), .cfg_duplex(cfg_duplex),
    .cfg_sel_en(cfg_sel_en), .cfg_sel_pol(cfg_sel_pol), .run(run), .busy(busy),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .sclk(sclk), .mosi(mosi), .miso(miso), .sel(sel)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(busy === 1'b0, "R10", "busy after reset", int'(busy), 0);
    check(rx_valid === 1'b0, "R10", "rx_valid after reset", int'(rx_valid), 0);
    check(tx_ready === 1'b0, "R10", "tx_ready after reset", int'(tx_ready), 0);
    check(sclk === 1'b0, "R10", "sclk idle after reset", int'(sclk), 0);
    check(sel === 1'b1, "R10", "sel inactive after reset", int'(sel), 1);
  endtask

  // One word with a bench-side target model; run is dropped as soon as busy is seen
  task automatic xfer_word(input bit ckp, input bit dap, input bit lsb, input bit wide,
                           input bit duplex, input logic [13:0] div,
                           input logic [15:0] txw, input logic [15:0] mis,
                           input bit sel_en, input bit sel_pol, input string tag);
    int w = wide ? 16 : 8;
    int n = (div == 0) ? 1 : int'(div);
    bit cpol = ~ckp;
    bit cpha = ~dap;
    logic [15:0] mask = wide ? 16'hFFFF : 16'h00FF;
    logic [15:0] cap = '0;
    logic [15:0] exp_mosi;
    int k = 0, edges = 0, bcnt = 0, after_run = 0, selbad = 0;
    bit seen = 0, acc = 0, trdy_seen = 0, prev, lead;
    @(negedge clk);
    cfg_ckp = ckp; cfg_dap = dap; cfg_lsb_first = lsb; cfg_wide = wide;
    cfg_duplex = duplex; cfg_div = div; cfg_sel_en = sel_en; cfg_sel_pol = sel_pol;
    tx_data = txw;
    #1;
    check(sclk === cpol, "R2", {tag, " idle sclk before word"}, int'(sclk), int'(cpol));
    miso = lsb ? mis[0] : mis[w-1];
    prev = sclk;
    run = 1'b1;
    tx_valid = duplex;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      @(negedge clk);
      if (acc) tx_valid = 1'b0;
      if (tx_ready) trdy_seen = 1;
      if (tx_valid && tx_ready) acc = 1;
      if (busy) begin
        seen = 1;
        bcnt++;
        if (!run) after_run++;
        run = 1'b0;
        if (sel_en && sel !== sel_pol) selbad++;
      end
      if (sclk !== prev) begin
        edges++;
        lead = (sclk !== cpol);
        if (cpha ? !lead : lead) begin
          cap[lsb ? k : w-1-k] = mosi;
          k++;
          if (k < w) miso = lsb ? mis[k] : mis[w-1-k];
        end
        prev = sclk;
      end
      if (seen && !busy) break;
    end
    tx_valid = 1'b0;
    exp_mosi = duplex ? (txw & mask) : mask;
    check(bcnt == 2*w*n, "R1", {tag, " busy cycles"}, bcnt, 2*w*n);
    check(after_run == 2*w*n - 1, "R8", {tag, " busy kept after run cleared"}, after_run, 2*w*n - 1);
    check(edges == 2*w, "R5", {tag, " serial clock edges"}, edges, 2*w);
    check(rx_valid === 1'b1, "R7", {tag, " rx_valid at end"}, int'(rx_valid), 1);
    check(rx_data === (mis & mask), tag, "received word", int'(rx_data), int'(mis & mask));
    check(cap === exp_mosi, duplex ? tag : "R6", "word seen on mosi", int'(cap), int'(exp_mosi));
    check(sclk === cpol, "R2", {tag, " sclk back to idle"}, int'(sclk), int'(cpol));
    check(selbad == 0, "R9", {tag, " sel active level while busy"}, selbad, 0);
    if (sel_en)
      check(sel === ~sel_pol, "R9", {tag, " sel inactive after word"}, int'(sel), int'(~sel_pol));
    else
      check(sel === 1'b0, "R9", {tag, " sel low when disabled"}, int'(sel), 0);
    if (!duplex)
      check(trdy_seen == 0, "R6", {tag, " tx_ready low in receive-only"}, int'(trdy_seen), 0);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    check(rx_valid === 1'b0, "R7", {tag, " rx_valid cleared by rx_ready"}, int'(rx_valid), 0);
  endtask

  // Receive-only with run left high: no new word while the received one waits
  task automatic test_rx_hold();
    logic [15:0] held;
    int idle_busy = 0;
    bit restarted = 0;
    @(negedge clk);
    cfg_ckp = 1'b1; cfg_dap = 1'b1; cfg_lsb_first = 1'b0; cfg_wide = 1'b0;
    cfg_duplex = 1'b0; cfg_div = 14'd1; cfg_sel_en = 1'b1; cfg_sel_pol = 1'b0;
    miso = 1'b1;
    run = 1'b1;
    for (int cyc = 0; cyc < 200; cyc++) begin
      @(negedge clk);
      if (rx_valid) break;
    end
    check(rx_valid === 1'b1, "R7", "hold: first word delivered", int'(rx_valid), 1);
    held = rx_data;
    for (int cyc = 0; cyc < 20; cyc++) begin
      @(negedge clk);
      if (busy) idle_busy++;
    end
    check(idle_busy == 0, "R7", "hold: no start while rx_valid", idle_busy, 0);
    check(rx_data === held, "R7", "hold: rx_data stable", int'(rx_data), int'(held));
    check(rx_data === 16'h00FF, "R6", "hold: receive-only word", int'(rx_data), 16'h00FF);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    for (int cyc = 0; cyc < 3; cyc++) begin
      @(negedge clk);
      if (busy) restarted = 1;
    end
    check(restarted == 1, "R7", "hold: restart once slot free", int'(restarted), 1);
    run = 1'b0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      @(negedge clk);
      if (!busy) break;
    end
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    rst = 1'b0;
    test_reset();
    // first-edge sampling, MSB first, 8-bit, active-low select
    xfer_word(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 14'd2, 16'h00A5, 16'h003C, 1'b1, 1'b0, "R3");
    // idle-high clock, second-edge sampling, LSB first, 16-bit, active-high select
    xfer_word(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 14'd3, 16'hC3A1, 16'h1E6B, 1'b1, 1'b1, "R4");
    // idle-low clock, second-edge sampling, MSB first, 16-bit
    xfer_word(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 14'd1, 16'h8001, 16'h7FFE, 1'b1, 1'b0, "R5");
    // idle-high clock, first-edge sampling, LSB first, 8-bit, divider zero, select disabled
    xfer_word(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 14'd0, 16'hFF96, 16'hAB59, 1'b0, 1'b0, "R1");
    // receive-only, 8-bit
    xfer_word(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 14'd2, 16'h0000, 16'h00C6, 1'b1, 1'b1, "R6");
    // receive-only, 16-bit LSB first, longer divider
    xfer_word(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 14'd5, 16'h1234, 16'hB00D, 1'b1, 1'b0, "R4");
    test_rx_hold();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule